// File: doc/BRIEF.md
# SMI Feature Handshake and APM Trigger Unit

This unit lets boot firmware negotiate, once per reset, which system-management-interrupt features it will use. The host side offers a fixed 64-bit feature set through a parameter. Firmware fills a 64-bit request register one byte at a time and then pulses a commit strobe. The unit checks the request against the offered set and against the dependency rules between the broadcast, CPU-hotplug and CPU-unplug bits. A request that passes is copied into the negotiated register and the ok flag rises. Both stay frozen until the next reset.

The unit also decodes writes to the APM control port. The ACPI-enable command produces a one-cycle set pulse for the SCI enable bit, and the ACPI-disable command produces a one-cycle clear pulse. Any other value raises SMI, but only while the APMC enable input from the power-management register file is high. If broadcast was negotiated, SMI goes to every CPU. Otherwise it goes only to the CPU that made the write.

Top module: `smi_feature_gate`

## Requirements
- R1: While reset is asserted and right after it is released, reqFeatures, negFeatures, featuresOk, sciEnSet, sciEnClr and smiReq are all zero. A reset clears a previously locked negotiation.
- R2: A byte write with index i (0 to 7) places the data in reqFeatures bits [8i+7:8i], so byte 0 is the least significant byte. The new value is visible one cycle after the write.
- R3: While featuresOk is 1, byte writes leave reqFeatures unchanged.
- R4: A commit whose request has any bit outside HOST_FEATURES is rejected: featuresOk and negFeatures stay 0.
- R5: A commit that requests hotplug (bit HP_BIT, default 1) or unplug (bit UP_BIT, default 2) without broadcast (bit BC_BIT, default 0) is rejected.
- R6: A commit that requests unplug without hotplug is rejected. A HOST_FEATURES value with unplug but without hotplug is a configuration error.
- R7: A commit that passes validation sets featuresOk to 1 and loads the request into negFeatures, both one cycle after the commit. An all-zero request is valid.
- R8: Once featuresOk is 1, further commits are ignored and negFeatures does not change.
- R9: An APM write of ACPI_EN_CMD (default 8'hF1) gives a one-cycle sciEnSet pulse. An APM write of ACPI_DIS_CMD (default 8'hF0) gives a one-cycle sciEnClr pulse. Neither raises SMI.
- R10: An APM write of any other value raises SMI one cycle later, for one cycle, only if smiApmcEn is 1.
- R11: The raised SMI drives every bit of smiReq when negFeatures[BC_BIT] is 1. Otherwise it drives only bit apmCpuId.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqWrEn | input | 1 | Write one byte of the request register |
| reqByteIdx | input | 3 | Byte index, 0 = least significant |
| reqWrData | input | 8 | Byte value |
| okWrEn | input | 1 | Commit strobe that starts validation |
| apmWrEn | input | 1 | APM control-port write |
| apmWrData | input | 8 | APM command value |
| apmCpuId | input | CPU_ID_W | Index of the CPU making the APM write |
| smiApmcEn | input | 1 | APMC enable bit from the SMI enable register |
| reqFeatures | output | 64 | Current request register |
| negFeatures | output | 64 | Locked negotiated features |
| featuresOk | output | 1 | Negotiation succeeded and is locked |
| sciEnSet | output | 1 | Pulse that sets SCI enable |
| sciEnClr | output | 1 | Pulse that clears SCI enable |
| smiReq | output | NUM_CPUS | Per-CPU SMI request pulse |

## Verification
The bench builds the unit with four CPUs. It widens the offered set to 64'h8000_0000_0000_0007, which adds bit 63 to the three dependency bits. A request that uses the top byte can therefore be accepted, while a neighbouring high bit that is not offered must still be refused. With four CPUs, a single-target SMI can be told apart from a broadcast one.

// File: rtl/smi_feature_pkg.sv
package smi_feature_pkg;
  // Strobes issued by the control module to the datapath
  typedef struct packed {
    logic reqWr;   // accept a request byte
    logic commit;  // lock in the current request
    logic sciSet;  // ACPI enable command seen
    logic sciClr;  // ACPI disable command seen
    logic smiAll;  // SMI to every CPU
    logic smiOne;  // SMI to the requesting CPU
  } smi_strobe_t;
endpackage

// File: rtl/smi_feature_ctrl.sv
module smi_feature_ctrl
  import smi_feature_pkg::*;
#(
  parameter logic [63:0] HOST_FEATURES = 64'h7,
  parameter int          BC_BIT        = 0,
  parameter int          HP_BIT        = 1,
  parameter int          UP_BIT        = 2,
  parameter logic [7:0]  ACPI_EN_CMD   = 8'hF1,
  parameter logic [7:0]  ACPI_DIS_CMD  = 8'hF0
) (
  input  logic        reqWrEn,
  input  logic        okWrEn,
  input  logic        apmWrEn,
  input  logic [7:0]  apmWrData,
  input  logic        smiApmcEn,
  input  logic [63:0] reqFeatures,
  input  logic        featuresOk,
  input  logic        negBcast,
  output smi_strobe_t strobe
);
  logic outsideHost;
  logic needsBcast;
  logic unplugAlone;
  logic reqValid;
  logic isEnCmd;
  logic isDisCmd;
  logic smiFire;

  initial begin
    AST_HOST_CFG: assert (!(HOST_FEATURES[UP_BIT] && !HOST_FEATURES[HP_BIT])) // R6
      else $error("offered set has unplug without hotplug");
  end

  always_comb begin
    outsideHost = |(reqFeatures & ~HOST_FEATURES);
    needsBcast  = (reqFeatures[HP_BIT] | reqFeatures[UP_BIT]) & ~reqFeatures[BC_BIT];
    unplugAlone = reqFeatures[UP_BIT] & ~reqFeatures[HP_BIT];
    reqValid    = ~outsideHost & ~needsBcast & ~unplugAlone;

    isEnCmd  = (apmWrData == ACPI_EN_CMD);
    isDisCmd = (apmWrData == ACPI_DIS_CMD);
    smiFire  = apmWrEn & ~isEnCmd & ~isDisCmd & smiApmcEn;

    strobe.reqWr  = reqWrEn & ~featuresOk;
    strobe.commit = okWrEn & ~featuresOk & reqValid;
    strobe.sciSet = apmWrEn & isEnCmd;
    strobe.sciClr = apmWrEn & isDisCmd;
    strobe.smiAll = smiFire & negBcast;
    strobe.smiOne = smiFire & ~negBcast;
  end
endmodule

// File: rtl/smi_feature_dpath.sv
module smi_feature_dpath
  import smi_feature_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int CPU_ID_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  smi_strobe_t         strobe,
  input  logic [2:0]          reqByteIdx,
  input  logic [7:0]          reqWrData,
  input  logic [CPU_ID_W-1:0] apmCpuId,
  output logic [63:0]         reqFeatures,
  output logic [63:0]         negFeatures,
  output logic                featuresOk,
  output logic                sciEnSet,
  output logic                sciEnClr,
  output logic [NUM_CPUS-1:0] smiReq
);
  localparam int NUM_BYTES = 8;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_reqByte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) reqFeatures[8*b +: 8] <= '0;
      else if (strobe.reqWr && reqByteIdx == 3'(b)) reqFeatures[8*b +: 8] <= reqWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      negFeatures <= '0;
      featuresOk  <= 1'b0;
      sciEnSet    <= 1'b0;
      sciEnClr    <= 1'b0;
    end else begin
      if (strobe.commit) begin
        negFeatures <= reqFeatures;
        featuresOk  <= 1'b1;
      end
      sciEnSet <= strobe.sciSet;
      sciEnClr <= strobe.sciClr;
    end
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_smiLine
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) smiReq[c] <= 1'b0;
      else smiReq[c] <= strobe.smiAll | (strobe.smiOne && apmCpuId == CPU_ID_W'(c));
    end
  end

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    featuresOk |=> (featuresOk && $stable(negFeatures))) else $error("lock lost"); // R8
  AST_REQ_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    featuresOk |=> $stable(reqFeatures)) else $error("request changed while locked"); // R3
  AST_SCI_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(sciEnSet && sciEnClr)) else $error("set and clear together"); // R9
  AST_SMI_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (smiReq != '0) |-> (smiReq == '1 || $onehot(smiReq))) else $error("bad SMI pattern"); // R11
endmodule

// File: rtl/smi_feature_gate.sv
module smi_feature_gate
  import smi_feature_pkg::*;
#(
  parameter int          NUM_CPUS      = 4,
  parameter logic [63:0] HOST_FEATURES = 64'h7,
  parameter int          BC_BIT        = 0,
  parameter int          HP_BIT        = 1,
  parameter int          UP_BIT        = 2,
  parameter logic [7:0]  ACPI_EN_CMD   = 8'hF1,
  parameter logic [7:0]  ACPI_DIS_CMD  = 8'hF0,
  localparam int         CPU_ID_W      = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqWrEn,
  input  logic [2:0]          reqByteIdx,
  input  logic [7:0]          reqWrData,
  input  logic                okWrEn,
  input  logic                apmWrEn,
  input  logic [7:0]          apmWrData,
  input  logic [CPU_ID_W-1:0] apmCpuId,
  input  logic                smiApmcEn,
  output logic [63:0]         reqFeatures,
  output logic [63:0]         negFeatures,
  output logic                featuresOk,
  output logic                sciEnSet,
  output logic                sciEnClr,
  output logic [NUM_CPUS-1:0] smiReq
);
  smi_strobe_t strobe;

  smi_feature_ctrl #(
    .HOST_FEATURES(HOST_FEATURES), .BC_BIT(BC_BIT), .HP_BIT(HP_BIT), .UP_BIT(UP_BIT),
    .ACPI_EN_CMD(ACPI_EN_CMD), .ACPI_DIS_CMD(ACPI_DIS_CMD)
  ) i_ctrl (
    .reqWrEn(reqWrEn), .okWrEn(okWrEn), .apmWrEn(apmWrEn), .apmWrData(apmWrData),
    .smiApmcEn(smiApmcEn), .reqFeatures(reqFeatures), .featuresOk(featuresOk),
    .negBcast(negFeatures[BC_BIT]), .strobe(strobe)
  );

  smi_feature_dpath #(.NUM_CPUS(NUM_CPUS), .CPU_ID_W(CPU_ID_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqByteIdx(reqByteIdx),
    .reqWrData(reqWrData), .apmCpuId(apmCpuId), .reqFeatures(reqFeatures),
    .negFeatures(negFeatures), .featuresOk(featuresOk), .sciEnSet(sciEnSet),
    .sciEnClr(sciEnClr), .smiReq(smiReq)
  );

  AST_ONLY_HOST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(featuresOk) |-> ((negFeatures & ~HOST_FEATURES) == '0)) else $error("foreign bit locked"); // R4
  AST_HP_NEEDS_BC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(featuresOk) |-> (negFeatures[BC_BIT] || !(negFeatures[HP_BIT] || negFeatures[UP_BIT])))
    else $error("hotplug without broadcast"); // R5
  AST_UP_NEEDS_HP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(featuresOk) |-> (negFeatures[HP_BIT] || !negFeatures[UP_BIT])) else $error("unplug alone"); // R6
  AST_COPY_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(featuresOk) |-> (negFeatures == $past(reqFeatures))) else $error("copy mismatch"); // R7
  AST_SMI_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (smiReq != '0) |-> $past(apmWrEn && smiApmcEn)) else $error("ungated SMI"); // R10
  AST_SCI_NO_SMI: assert property (@(posedge clk) disable iff (!rstN)
    (sciEnSet || sciEnClr) |-> (smiReq == '0)) else $error("SCI command raised SMI"); // R9
endmodule

// File: tb/test_smi_feature_gate.sv
`timescale 1ns/1ps
module test_smi_feature_gate;
  localparam int          NCPU = 4;
  localparam logic [63:0] HOST = 64'h8000_0000_0000_0007;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqWrEn = 1'b0;
  logic [2:0]  reqByteIdx = '0;
  logic [7:0]  reqWrData = '0;
  logic        okWrEn = 1'b0;
  logic        apmWrEn = 1'b0;
  logic [7:0]  apmWrData = '0;
  logic [1:0]  apmCpuId = '0;
  logic        smiApmcEn = 1'b0;
  logic [63:0] reqFeatures, negFeatures;
  logic        featuresOk, sciEnSet, sciEnClr;
  logic [NCPU-1:0] smiReq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  smi_feature_gate #(.NUM_CPUS(NCPU), .HOST_FEATURES(HOST)) i_smi_feature_gate (
    .clk(clk), .rstN(rstN), .reqWrEn(reqWrEn), .reqByteIdx(reqByteIdx),
    .reqWrData(reqWrData), .okWrEn(okWrEn), .apmWrEn(apmWrEn), .apmWrData(apmWrData),
    .apmCpuId(apmCpuId), .smiApmcEn(smiApmcEn), .reqFeatures(reqFeatures),
    .negFeatures(negFeatures), .featuresOk(featuresOk), .sciEnSet(sciEnSet),
    .sciEnClr(sciEnClr), .smiReq(smiReq)
  );

  // {request, expected accept}
  localparam logic [64:0] VEC [10] = '{
    {64'h0, 1'b1},                    // R7 empty request
    {64'h1, 1'b1},                    // R7 broadcast only
    {64'h3, 1'b1},                    // R7 broadcast + hotplug
    {64'h7, 1'b1},                    // R7 all three
    {64'h2, 1'b0},                    // R5 hotplug alone
    {64'h4, 1'b0},                    // R5 unplug alone
    {64'h5, 1'b0},                    // R6 broadcast + unplug
    {64'h8, 1'b0},                    // R4 not offered
    {64'h8000_0000_0000_0001, 1'b1},  // R7 top byte offered
    {64'h4000_0000_0000_0000, 1'b0}   // R4 high bit not offered
  };

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset;
    rstN = 1'b0;
    tick();
    tick();
    rstN = 1'b1;
    tick();
  endtask

  task automatic writeByte(input logic [2:0] idx, input logic [7:0] data);
    reqWrEn = 1'b1; reqByteIdx = idx; reqWrData = data;
    tick();
    reqWrEn = 1'b0;
  endtask

  task automatic writeReq(input logic [63:0] v);
    for (int b = 0; b < 8; b++) writeByte(3'(b), v[8*b +: 8]);
  endtask

  task automatic commit;
    okWrEn = 1'b1;
    tick();
    okWrEn = 1'b0;
  endtask

  task automatic apmStart(input logic [7:0] data, input logic [1:0] cpu);
    apmWrEn = 1'b1; apmWrData = data; apmCpuId = cpu;
    tick();
    apmWrEn = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R1 reset req", reqFeatures, 64'h0);
    check("R1 reset ok", {63'h0, featuresOk}, 64'h0);
    doReset();
    check("R1 req", reqFeatures, 64'h0);
    check("R1 neg", negFeatures, 64'h0);
    check("R1 ok", {63'h0, featuresOk}, 64'h0);
    check("R1 pulses", {59'h0, sciEnSet, sciEnClr, smiReq}, 64'h0);

    for (int v = 0; v < 10; v++) begin
      doReset();
      writeReq(VEC[v][64:1]);
      commit();
      check($sformatf("R4/R5/R6/R7 vec%0d ok", v), {63'h0, featuresOk}, {63'h0, VEC[v][0]});
      check($sformatf("R4/R5/R6/R7 vec%0d neg", v), negFeatures,
            VEC[v][0] ? VEC[v][64:1] : 64'h0);
    end

    // R2 byte placement
    doReset();
    writeByte(3'd3, 8'hA5);
    check("R2 byte3", reqFeatures, 64'h0000_0000_A500_0000);
    writeByte(3'd0, 8'h5A);
    check("R2 byte0", reqFeatures, 64'h0000_0000_A500_005A);

    // R3 / R8 lock
    doReset();
    writeReq(64'h1);
    commit();
    writeByte(3'd0, 8'h07);
    check("R3 req frozen", reqFeatures, 64'h1);
    commit();
    check("R8 neg held", negFeatures, 64'h1);
    check("R8 ok held", {63'h0, featuresOk}, 64'h1);

    // R11 broadcast negotiated
    smiApmcEn = 1'b1;
    apmStart(8'h42, 2'd1);
    check("R11 broadcast", {60'h0, smiReq}, 64'hF);
    tick();
    check("R10 single pulse", {60'h0, smiReq}, 64'h0);

    // R1 reset clears lock
    doReset();
    check("R1 lock cleared", {negFeatures[62:0], featuresOk}, 64'h0);

    // R11 single target, R10 gating
    apmStart(8'h42, 2'd2);
    check("R11 single target", {60'h0, smiReq}, 64'h4);
    tick();
    smiApmcEn = 1'b0;
    apmStart(8'h42, 2'd2);
    check("R10 gated off", {60'h0, smiReq}, 64'h0);
    smiApmcEn = 1'b1;

    // R9 ACPI commands
    apmStart(8'hF1, 2'd0);
    check("R9 set pulse", {58'h0, sciEnSet, sciEnClr, smiReq}, 64'h20);
    tick();
    check("R9 set ends", {63'h0, sciEnSet}, 64'h0);
    apmStart(8'hF0, 2'd0);
    check("R9 clr pulse", {58'h0, sciEnSet, sciEnClr, smiReq}, 64'h10);
    tick();
    check("R9 clr ends", {63'h0, sciEnClr}, 64'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule